// File: doc/BRIEF.md
# Nine-input parity generator and checker

This block reduces eight data bits plus one extra input bit to a pair of complementary parity flags. It also gives an error flag for the receiving end of a protected byte path. The same block serves both ends of the path.

At the sending end, the extra input is held at 1. The even flag is then exactly the bit to append to the byte so that the nine bits carried on the link hold an even number of ones. At the receiving end, the eight received data bits go to the data input and the received parity bit goes to the extra input. The error flag rises whenever the nine bits hold an odd number of ones.

The reduction is a network of two-input XOR gates. A parameter chooses between a balanced tree and a linear chain. There are no storage elements: every output follows its inputs within the same cycle.

Top module: `parity_gen_chk`

## Requirements
- R1: `odd_o` is 1 exactly when an odd number of the nine bits {`data_i`, `par_i`} are 1.
- R2: `even_o` is always the complement of `odd_o`.
- R3: `err_o` is 1 exactly when the nine-bit word {`data_i`, `par_i`} holds an odd count of ones, so it equals `odd_o`.
- R4: With `par_i` = 1, appending `even_o` to `data_i` gives a nine-bit word with an even number of ones.
- R5: A word built as in R4 and then changed in any single one of its nine bit positions (a data bit or the parity bit) gives `err_o` = 1.
- R6: A word built as in R4 and then changed in any two distinct bit positions gives `err_o` = 0.
- R7: The outputs are combinational. They reflect the inputs applied in the same cycle, with no clock and no reset.
- R8: The tree variant (`ARCH` = 0) and the chain variant (`ARCH` = 1) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W (8) | Data byte, either to be protected or as received |
| par_i | input | 1 | Ninth input: held at 1 when sending, the received parity bit when checking |
| odd_o | output | 1 | 1 when the nine inputs hold an odd number of ones |
| even_o | output | 1 | 1 when the nine inputs hold an even number of ones |
| err_o | output | 1 | Receive-side parity error |

## Verification
The bench sweeps all 512 values of the nine inputs through both structural variants. A tree that dropped or duplicated its padded leaf, or a chain that stopped one stage short, would give the wrong parity for patterns whose top or bottom bit is set.

For every byte, the bench then builds the sending-side word. It flips each of the nine positions in turn, and then every pair of positions. A checker that ignored the parity bit would miss flips of that bit. A checker that inverted its sense would flag clean words and double errors and would miss single errors.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int unsigned ARCH_TREE  = 0;
  localparam int unsigned ARCH_CHAIN = 1;

  // smallest power of two that is at least n
  function automatic int unsigned pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/parity_xor_tree.sv
module parity_xor_tree #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] bits_i,
  output logic         odd_o
);
  localparam int unsigned P   = parity_pkg::pow2_ceil(N);
  localparam int unsigned LVL = $clog2(P);

  logic [P-1:0] padded;
  always_comb begin
    padded = '0;
    padded[N-1:0] = bits_i;
  end

  for (genvar l = 0; l <= LVL; l++) begin : g_lvl
    localparam int unsigned W = P >> l;
    logic [W-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = padded;
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_x
        assign v[k] = g_lvl[l-1].v[2*k] ^ g_lvl[l-1].v[2*k+1];
      end
    end
  end

  assign odd_o = g_lvl[LVL].v[0];
endmodule

// File: rtl/parity_xor_chain.sv
module parity_xor_chain #(
  parameter int unsigned N = 9
) (
  input  logic [N-1:0] bits_i,
  output logic         odd_o
);
  logic acc;
  always_comb begin
    acc = bits_i[0];
    for (int k = 1; k < N; k++) acc = acc ^ bits_i[k];
  end
  assign odd_o = acc;
endmodule

// File: rtl/parity_gen_chk.sv
module parity_gen_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ARCH   = parity_pkg::ARCH_TREE
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              odd_o,
  output logic              even_o,
  output logic              err_o
);
  localparam int unsigned N = DATA_W + 1;

  logic [N-1:0] word;
  logic         odd_raw;

  assign word = {data_i, par_i};

  if (ARCH == parity_pkg::ARCH_CHAIN) begin : g_chain
    parity_xor_chain #(.N(N)) u_red (.bits_i(word), .odd_o(odd_raw));
  end else begin : g_tree
    parity_xor_tree #(.N(N)) u_red (.bits_i(word), .odd_o(odd_raw));
  end

  assign odd_o  = odd_raw;
  assign even_o = ~odd_raw;
  assign err_o  = odd_raw;

  always_comb begin
    assert_odd_count_R1: assert (odd_o == (($countones(word) % 2) == 1))
      else $error("odd flag disagrees with ones count");
    assert_even_compl_R2: assert (even_o != odd_o)
      else $error("even flag not complement of odd flag");
    assert_err_odd_R3: assert (err_o == (($countones(word) % 2) == 1))
      else $error("error flag disagrees with ones count");
    if (par_i) begin
      assert_tx_even_R4: assert (($countones({data_i, even_o}) % 2) == 0)
        else $error("generated bit leaves odd word");
    end
  end
endmodule

// File: tb/parity_gen_chk_test.sv
module parity_gen_chk_test;
  logic clk = 0;
  always #2 clk = ~clk;

  logic       rst;
  logic [7:0] data;
  logic       par;
  logic odd_t, even_t, err_t;
  logic odd_c, even_c, err_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  parity_gen_chk #(.DATA_W(8), .ARCH(0)) uut (
    .data_i(data), .par_i(par), .odd_o(odd_t), .even_o(even_t), .err_o(err_t));
  parity_gen_chk #(.DATA_W(8), .ARCH(1)) uut_chain (
    .data_i(data), .par_i(par), .odd_o(odd_c), .even_o(even_c), .err_o(err_c));

  function automatic int ones9(input logic [8:0] w);
    int c = 0;
    for (int i = 0; i < 9; i++) if (w[i]) c++;
    return c;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b data=%h par=%0b", req, act, exp, data, par);
    end
  endtask

  // apply at a rising edge, outputs are compared at the following falling edge
  task automatic apply(input logic [8:0] w);
    @(posedge clk);
    data = w[8:1];
    par  = w[0];
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic txbit;
    logic [8:0] base;
    rst = 1;
    data = '0;
    par = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 idle odd", odd_t, 1'b0);
    chk("R2 idle even", even_t, 1'b1);
    chk("R3 idle err", err_t, 1'b0);
    rst = 0;

    // exhaustive sweep, R1 R2 R3 R7 R8
    for (int w = 0; w < 512; w++) begin
      logic exp_odd;
      apply(9'(w));
      exp_odd = (ones9(9'(w)) % 2) == 1;
      chk("R1 odd tree", odd_t, exp_odd);
      chk("R2 even tree", even_t, ~exp_odd);
      chk("R3 err tree", err_t, exp_odd);
      chk("R8 odd chain", odd_c, exp_odd);
      chk("R8 even chain", even_c, ~exp_odd);
      chk("R7 err chain same cycle", err_c, exp_odd);
    end

    // send side then receive side with corruptions
    for (int d = 0; d < 256; d++) begin
      apply({8'(d), 1'b1});
      txbit = even_t;
      base = {8'(d), txbit};
      checks++;
      if ((ones9(base) % 2) != 0) begin
        errors++;
        $display("FAIL R4 actual=odd expected=even data=%h bit=%0b", d[7:0], txbit);
      end
      apply(base);
      chk("R3 clean word err", err_t, 1'b0);
      for (int i = 0; i < 9; i++) begin
        apply(base ^ (9'd1 << i));
        chk("R5 single flip tree", err_t, 1'b1);
        chk("R5 single flip chain", err_c, 1'b1);
      end
      for (int i = 0; i < 9; i++) begin
        for (int j = i + 1; j < 9; j++) begin
          apply(base ^ (9'd1 << i) ^ (9'd1 << j));
          chk("R6 double flip", err_t, 1'b0);
        end
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule